// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial characters. Each write strobe places one byte into a 16-entry queue. A shift sequencer takes the bytes from the queue in order and sends each one on a single output line. Each character has a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. A line-control setting on the block's inputs selects the data length, parity and stop bits.

Bit timing comes from an external tick that runs at sixteen times the bit rate. Each serial bit lasts exactly sixteen ticks. The block reports two flags:
- The holding-empty flag is set when the queue holds no bytes.
- The transmitter-empty flag is set when the queue and the shifter are both idle.

An interrupt request follows the holding-empty flag whenever the interrupt enable is high. The request is set straight out of reset, and software can clear it only by writing a byte.

Top module: `uart_tx_buffered`

## Requirements
- R1: After synchronous reset, `txd` is 1, `hold_empty` and `tx_empty` are 1, and `line_status` reads 8'h60. Bit 5 of `line_status` is the holding-empty flag and bit 6 is the transmitter-empty flag; all other bits are 0.
- R2: `tx_irq` equals `hold_empty` AND `irq_en`. Writing a byte makes `hold_empty` and `tx_irq` read 0 on the next cycle.
- R3: The queue holds up to 16 bytes. Bytes leave on the line in the order they were written.
- R4: A write while the queue holds 16 bytes is dropped. The bytes already queued are sent unchanged, and no extra character appears.
- R5: Data bits are sent least-significant first. `len_sel` 2'b00, 2'b01, 2'b10 and 2'b11 select 5, 6, 7 and 8 data bits.
- R6: The start bit and every later bit stay on `txd` for exactly 16 `baud_tick` pulses. `txd` changes only on a clock edge where `baud_tick` is 1.
- R7: When `par_en` is 1, a parity bit follows the data bits. With `par_odd` = 0 the parity bit makes the number of ones in data plus parity even. With `par_odd` = 1 it makes that number odd. When `par_en` is 0, no parity bit is sent.
- R8: `two_stop` = 0 sends one stop bit of value 1, and `two_stop` = 1 sends two.
- R9: `txd` is 1 whenever nothing is being sent. `tx_empty` is 1 only when the queue and the shifter are both empty.
- R10: The next queued byte loads only after the final stop bit has finished. Its start bit begins on the following tick, so consecutive start bits are (frame bits × 16 + 1) ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding port |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| len_sel | input | 2 | Data length select (5 to 8 bits) |
| two_stop | input | 1 | Two stop bits when 1 |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| irq_en | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial output line |
| line_status | output | 8 | Status word: bit 5 holding empty, bit 6 transmitter empty |
| hold_empty | output | 1 | Queue holds no bytes |
| tx_empty | output | 1 | Queue and shifter both empty |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench fills the queue with ticks stopped, adds a seventeenth write, and then lets the queue drain. A design that overwrote an entry or wrapped a pointer would send a wrong byte or an extra character. A design that loaded the next byte before the stop bit ended would shorten the spacing between start bits. Every data length and parity mode is decoded at mid-bit, so a reversed bit order, a wrong data length or an inverted parity sense shows up as a data or parity mismatch. Bit timing is checked as well: a bit one tick too long or too short drifts the sample points enough to fail the later bits. The interrupt is watched straight out of reset, right after a write, and after the byte has moved into the shifter.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

    localparam int BYTE_W              = 8;
    localparam int STATUS_HOLD_EMPTY_B = 5;
    localparam int STATUS_TX_EMPTY_B   = 6;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       two_stop;
        logic       par_en;
        logic       par_odd;
    } line_cfg_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_PAR,
        SH_STOP
    } sh_state_t;

    function automatic logic [3:0] data_bits(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    function automatic logic [BYTE_W-1:0] width_mask(input logic [1:0] sel);
        logic [1:0] drop;
        drop = 2'd3 - sel;
        return 8'hFF >> drop;
    endfunction

    function automatic logic parity_of(input logic [BYTE_W-1:0] data,
                                       input logic [1:0] sel,
                                       input logic odd);
        return (^(data & width_mask(sel))) ^ odd;
    endfunction

endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             valid,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign valid   = (cnt_q != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign head    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/txb_shifter.sv
module txb_shifter
    import uart_txb_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              ld_valid,
    input  logic [BYTE_W-1:0] ld_data,
    output logic              ld_take,
    output logic              txd,
    output logic              busy
);
    localparam int SUBW = $clog2(TICKS_PER_BIT);

    sh_state_t         st_q;
    logic [SUBW-1:0]   sub_q;
    logic [BYTE_W-1:0] sh_q;
    logic [2:0]        idx_q;
    logic              par_q;
    logic              stop2_q;
    line_cfg_t         cfg_q;
    logic              bit_end;
    logic              last_data;

    assign ld_take   = tick && (st_q == SH_IDLE) && ld_valid;
    assign bit_end   = tick && (sub_q == SUBW'(TICKS_PER_BIT - 1));
    assign last_data = (idx_q == 3'(data_bits(cfg_q.len_sel) - 4'd1));
    assign busy      = (st_q != SH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SH_IDLE;
            sub_q   <= '0;
            sh_q    <= '0;
            idx_q   <= '0;
            par_q   <= 1'b0;
            stop2_q <= 1'b0;
            cfg_q   <= '0;
        end else if (ld_take) begin
            st_q    <= SH_START;
            sub_q   <= '0;
            sh_q    <= ld_data;
            idx_q   <= '0;
            par_q   <= parity_of(ld_data, cfg.len_sel, cfg.par_odd);
            stop2_q <= 1'b0;
            cfg_q   <= cfg;
        end else if (tick && busy) begin
            if (!bit_end) begin
                sub_q <= sub_q + 1'b1;
            end else begin
                sub_q <= '0;
                unique case (st_q)
                    SH_START: begin
                        st_q  <= SH_DATA;
                        idx_q <= '0;
                    end
                    SH_DATA: begin
                        sh_q  <= sh_q >> 1;
                        idx_q <= idx_q + 1'b1;
                        if (last_data) st_q <= cfg_q.par_en ? SH_PAR : SH_STOP;
                    end
                    SH_PAR:  st_q <= SH_STOP;
                    SH_STOP: begin
                        if (cfg_q.two_stop && !stop2_q) stop2_q <= 1'b1;
                        else                            st_q    <= SH_IDLE;
                    end
                    default: st_q <= SH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (st_q)
            SH_START: txd = 1'b0;
            SH_DATA:  txd = sh_q[0];
            SH_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
    import uart_txb_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic [1:0]        len_sel,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              irq_en,
    output logic              txd,
    output logic [7:0]        line_status,
    output logic              hold_empty,
    output logic              tx_empty,
    output logic              tx_irq
);
    line_cfg_t         cfg_in;
    logic [BYTE_W-1:0] q_head;
    logic              q_valid, q_full, q_pop, sh_busy;

    assign cfg_in = '{len_sel: len_sel, two_stop: two_stop,
                      par_en: par_en, par_odd: par_odd};

    txb_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (q_pop),
        .head      (q_head),
        .valid     (q_valid),
        .full      (q_full)
    );

    txb_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .cfg      (cfg_in),
        .ld_valid (q_valid),
        .ld_data  (q_head),
        .ld_take  (q_pop),
        .txd      (txd),
        .busy     (sh_busy)
    );

    assign hold_empty = !q_valid;
    assign tx_empty   = !q_valid && !sh_busy;
    assign tx_irq     = hold_empty && irq_en;

    always_comb begin
        line_status                      = '0;
        line_status[STATUS_HOLD_EMPTY_B] = hold_empty;
        line_status[STATUS_TX_EMPTY_B]   = tx_empty;
    end

    logic unused_full;
    assign unused_full = q_full;
endmodule

// File: rtl/uart_tx_buffered_chk.sv
module uart_tx_buffered_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic baud_tick,
    input logic irq_en,
    input logic txd,
    input logic hold_empty,
    input logic tx_empty,
    input logic tx_irq
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (txd && hold_empty && tx_empty));

    p_write_clears_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!hold_empty && !tx_irq));

    p_irq_gated_r2: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !tx_irq);

    p_tick_paced_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(baud_tick));

    p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);

    p_empty_order_r9: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);
endmodule

bind uart_tx_buffered uart_tx_buffered_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .baud_tick  (baud_tick),
    .irq_en     (irq_en),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .tx_irq     (tx_irq)
);

// File: tb/uart_tx_buffered_tb.sv
module uart_tx_buffered_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TP         = 2;
    localparam int BITC       = 16 * TP;

    typedef struct {
        logic [7:0] d;
        logic [1:0] len;
        logic       two;
        logic       pe;
        logic       po;
        logic       chained;
    } exp_t;

    exp_t q[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic [1:0] len_sel = 2'b11;
    logic       two_stop = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       irq_en = 1'b0;
    logic       txd;
    logic [7:0] line_status;
    logic       hold_empty, tx_empty, tx_irq;

    logic tick_on = 1'b0;
    logic ph = 1'b0;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   frames = 0;
    int   exp_frames = 0;
    int   last_start = 0;
    int   last_bits = 0;
    bit   finished = 0;

    uart_tx_buffered u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .baud_tick (baud_tick), .len_sel (len_sel), .two_stop (two_stop),
        .par_en (par_en), .par_odd (par_odd), .irq_en (irq_en), .txd (txd),
        .line_status (line_status), .hold_empty (hold_empty),
        .tx_empty (tx_empty), .tx_irq (tx_irq)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;
    initial forever begin @(posedge clk); cyc = cyc + 1; end
    initial forever begin
        @(negedge clk);
        ph = ~ph;
        baud_tick = tick_on & ph;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic exp_parity(input exp_t e);
        int ones = 0;
        for (int i = 0; i < 5 + int'(e.len); i++) ones += int'(e.d[i]);
        return logic'(ones % 2) ^ e.po;
    endfunction

    // driver: writes one byte, optionally recording the expected frame
    task automatic put(input logic [7:0] d, input bit expect_it, input bit chained);
        exp_t e;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (expect_it) begin
            e = '{d: d, len: len_sel, two: two_stop, pe: par_en, po: par_odd, chained: chained};
            q.push_back(e);
            exp_frames++;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        int w = 0;
        while ((q.size() != 0 || !tx_empty) && w < 60000) begin
            @(negedge clk);
            w++;
        end
        repeat (BITC + 4) @(negedge clk);
        check(tx_empty && txd, "R9 drained idle", {tx_empty, txd}, 2'b11);
    endtask

    // monitor: decodes frames at mid-bit and compares with the queue
    task automatic frame();
        exp_t e;
        int   st = cyc;
        int   nb, bits;
        logic [7:0] got = '0;
        frames++;
        if (q.size() == 0) begin
            check(1'b0, "R4 unexpected frame", frames, exp_frames);
            repeat (BITC * 8) @(negedge clk);
            return;
        end
        e = q.pop_front();
        nb = 5 + int'(e.len);
        bits = 1 + nb + int'(e.pe) + 1 + int'(e.two);
        if (e.chained)
            check(st - last_start == (last_bits * 16 + 1) * TP, "R10 start spacing",
                  st - last_start, (last_bits * 16 + 1) * TP);
        last_start = st;
        last_bits  = bits;
        repeat (BITC / 2) @(negedge clk);
        check(txd == 1'b0, "R6 start bit", txd, 0);
        for (int i = 0; i < nb; i++) begin
            repeat (BITC) @(negedge clk);
            got[i] = txd;
        end
        check(got == (e.d & (8'hFF >> (3 - int'(e.len)))), "R5/R3 data",
              got, e.d & (8'hFF >> (3 - int'(e.len))));
        if (e.pe) begin
            repeat (BITC) @(negedge clk);
            check(txd == exp_parity(e), "R7 parity", txd, exp_parity(e));
        end
        repeat (BITC) @(negedge clk);
        check(txd == 1'b1, "R8 stop bit 1", txd, 1);
        if (e.two) begin
            repeat (BITC) @(negedge clk);
            check(txd == 1'b1, "R8 stop bit 2", txd, 1);
        end
    endtask

    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst && prev && !txd) frame();
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", txd, 1);
        check(hold_empty && tx_empty, "R1 empty flags", {hold_empty, tx_empty}, 2'b11);
        check(line_status == 8'h60, "R1 status word", line_status, 8'h60);
        check(tx_irq == 1'b0, "R2 irq masked", tx_irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(tx_irq == 1'b1, "R2 irq after reset", tx_irq, 1);

        // R2 write clears, ticks held off
        put(8'hA5, 1, 0);
        check(!hold_empty && !tx_irq, "R2 write clears irq", {hold_empty, tx_irq}, 2'b00);
        check(!tx_empty && line_status == 8'h00, "R9 status busy", line_status, 8'h00);
        tick_on = 1'b1;
        repeat (6) @(negedge clk);
        check(hold_empty && tx_irq && !tx_empty, "R9 byte in shifter",
              {hold_empty, tx_irq, tx_empty}, 3'b110);
        drain();

        // R5 R7 R8 each length with varied framing, two chained bytes each
        for (int l = 0; l < 4; l++) begin
            len_sel  = 2'(l);
            par_en   = (l != 0);
            par_odd  = l[0];
            two_stop = l[1];
            put(8'h35 + 8'(l * 75), 1, 0);
            put(8'hC6 ^ 8'(l * 29), 1, 1);
            drain();
        end
        len_sel = 2'b10; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b0;
        put(8'h7E, 1, 0);
        drain();

        // R3 R4 fill the queue, then write once more while full
        len_sel = 2'b11; par_en = 1'b0; two_stop = 1'b0;
        tick_on = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 17; i++) put(8'h10 + 8'(i * 7), i < 16, i > 0);
        check(!hold_empty, "R3 queue holds bytes", hold_empty, 0);
        tick_on = 1'b1;
        drain();
        check(frames == exp_frames, "R4 frame count", frames, exp_frames);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule